// File: doc/BRIEF.md
# Prescaled ADC Start-of-Conversion Pulser

This block turns timer event strobes from a PWM time base into start-of-conversion pulses for an ADC. It has up to four channels, and each channel works on its own. A channel picks one event from the shared strobe vector and counts how often that event occurs. When the count reaches the channel's period, which can be 1 to 7, the channel emits a one-clock pulse and starts counting from zero again.

Each channel has a sticky flag that records that a pulse went out. Software can clear the flag, but the flag never holds back later pulses. A channel enable gates only the pulse output. While the enable is low, the counter still runs up to the period and then waits there. A period of 0 turns the channel off completely.

Channels A and B can also select a combined source: the OR of the strobes picked by that channel's own mask. A build parameter removes channels C and D.

Top module: `socgen`

## Requirements
- R1: While reset is low, and at the first sample after reset, every pulse, flag and count output is 0.
- R2: With period P in 1..7 and the enable high, each selected event that is sampled at a clock edge and not yet blocked adds 1 to the count. The edge that samples the P-th event sets the pulse, and at the same edge the count goes to 0.
- R3: Each pulse lasts one clock. When the period is 2 or more at the clock edge where a pulse is visible, the next cycle has no pulse.
- R4: A pulse sets the channel flag in the same edge. The flag stays set, and a set flag never stops later pulses.
- R5: A clear bit of 1 clears the channel flag at the next edge. If a pulse fires at that same edge, the flag ends up set.
- R6: With the enable low, no pulse is output and the count stops rising once it equals the period. If the enable is raised while the count equals the period, a pulse follows at the next edge without a new event.
- R7: A period of 0 forces the count to 0 and produces no pulse, whatever events arrive.
- R8: Select codes over the event vector are: 0 none, 1 bit0 (counter zero), 2 bit1 (counter period), 3 bit0 or bit1, 4..13 event bit (code-2) (bits 2..9 are compare A-up, A-down, B-up, B-down, C-up, C-down, D-up, D-down; bit10 one-shot trip; bit11 cycle-by-cycle trip), 14 mix source, 15 none.
- R9: Code 14 on channel A is the OR of event bits enabled in mix mask A, and on channel B the OR of those enabled in mix mask B. On channels C and D, code 14 selects nothing.
- R10: With FOUR_CH=0 the block has channels A and B only, and they behave exactly like channels A and B of the four-channel build.
- R11: If the period is lowered to a value at or below the current count, the count is treated as having reached the period. A pulse follows at the next edge when the enable is high; otherwise the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_evt | input | 12 | Time-base event strobes, one-cycle pulses (bit map in R8) |
| ch_sel | input | NCH*4 | Per-channel event select code, channel n at bits [4n+3:4n] |
| ch_prd | input | NCH*PW | Per-channel prescale period, channel n at bits [PW*n+PW-1:PW*n] |
| ch_en | input | NCH | Per-channel pulse enable |
| ch_clr | input | NCH | Per-channel flag clear, acts when 1 |
| mix_mask_a | input | 12 | Event mask for the channel A mix source |
| mix_mask_b | input | 12 | Event mask for the channel B mix source |
| soc_pulse | output | NCH | Start-of-conversion pulses |
| soc_flag | output | NCH | Sticky pulse flags |
| soc_cnt | output | NCH*PW | Current event counts, packed like ch_prd |

## Verification
The directed cases start with a steady stream on the zero strobe at period 3. This separates a counter that fires on the P-th event from one that fires one event early or late. A disabled channel fed with period strobes shows that the count stops at the period and that the held count fires the moment the enable rises. Further cases cover:
- a period-0 channel fed with trip strobes;
- a clear that lands on the same edge as a pulse, which shows whether set or clear wins;
- mix selects with matching and non-matching strobes, which shows that the mask and the channel restriction are both applied;
- a period lowered under the live count.

Random select codes, periods, enables, clears and sparse strobe patterns then exercise every decode path against the bench model. A two-channel build runs in parallel to confirm that it matches the wider build.

// File: rtl/socgen_pkg.sv
// Package socgen_pkg
// Shared constants and the event select encoding for the start-of-conversion
// pulser. Assumes a 12-bit event strobe vector with the bit map listed below.
package socgen_pkg;

    localparam int NUM_EVT = 12;
    localparam int SEL_W   = 4;

    // Event strobe bit positions inside tb_evt
    localparam int EB_ZERO = 0;
    localparam int EB_PRD  = 1;
    localparam int EB_OST  = 10;
    localparam int EB_CBC  = 11;

    // Select codes; 4..13 pick event bit (code - 2)
    typedef enum logic [SEL_W-1:0] {
        SEL_NONE = 4'd0,
        SEL_ZERO = 4'd1,
        SEL_PRD  = 4'd2,
        SEL_ZP   = 4'd3,
        SEL_AU   = 4'd4,
        SEL_AD   = 4'd5,
        SEL_BU   = 4'd6,
        SEL_BD   = 4'd7,
        SEL_CU   = 4'd8,
        SEL_CD   = 4'd9,
        SEL_DU   = 4'd10,
        SEL_DD   = 4'd11,
        SEL_OST  = 4'd12,
        SEL_CBC  = 4'd13,
        SEL_MIX  = 4'd14,
        SEL_OFF  = 4'd15
    } sel_e;

endpackage

// File: rtl/soc_evt_pick.sv
// Module soc_evt_pick
// Turns a channel's select code into a single event hit for this cycle.
// Assumes event strobes are already synchronous one-cycle pulses. When
// HAS_MIX is 0, the mix code selects nothing and the mask is unused.
module soc_evt_pick
    import socgen_pkg::*;
#(
    parameter bit HAS_MIX = 1'b1
) (
    input  logic [NUM_EVT-1:0] evt,
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_EVT-1:0] mix_mask,
    output logic               hit
);

    logic mix_hit;

    // Mix source: OR of the masked strobes, present only when HAS_MIX is set
    generate
        if (HAS_MIX) begin : g_mix
            assign mix_hit = |(evt & mix_mask);
        end else begin : g_nomix
            logic unused_mask;
            assign unused_mask = |mix_mask;
            assign mix_hit     = 1'b0;
        end
    endgenerate

    // Decode the select code into one event hit
    always_comb begin
        unique case (sel_e'(sel))
            SEL_NONE, SEL_OFF: hit = 1'b0;
            SEL_ZERO:          hit = evt[EB_ZERO];
            SEL_PRD:           hit = evt[EB_PRD];
            SEL_ZP:            hit = evt[EB_ZERO] | evt[EB_PRD];
            SEL_MIX:           hit = mix_hit;
            default:           hit = evt[sel - 4'd2];
        endcase
    end

    // R9: with no mix path, the mix code can never produce a hit
    always_comb begin
        if (!HAS_MIX && sel == SEL_MIX)
            assert_no_mix_R9: assert (!hit);
    end

endmodule

// File: rtl/soc_chan.sv
// Module soc_chan
// One prescaler channel. It counts selected events up to the period and fires
// a one-cycle pulse when the period is reached and the enable is high. It also
// keeps a sticky flag that a pulse sets and that the clear input resets.
// Assumes period 0 means off and that all inputs are synchronous to clk.
module soc_chan #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic [PW-1:0] prd,
    input  logic          en,
    input  logic          clr,
    output logic          pulse,
    output logic          flag,
    output logic [PW-1:0] cnt
);

    logic          inc;
    logic [PW-1:0] nxt;
    logic          reach;
    logic          fire;

    // Next count, saturating at the period; decide whether to fire
    always_comb begin
        inc   = hit && (cnt < prd);
        nxt   = cnt + PW'(inc);
        reach = (prd != '0) && (nxt >= prd);
        fire  = reach && en;
    end

    // Counter and pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= fire;
            if (prd == '0 || fire)
                cnt <= '0;
            else
                cnt <= nxt;
        end
    end

    // Sticky flag: a pulse wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (fire)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    assert_cnt_zero_at_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (cnt == '0));

    assert_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && prd >= PW'(2)) |=> !pulse);

    assert_flag_with_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> flag);

    assert_flag_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !fire) |=> !flag);

    assert_no_pulse_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pulse);

    assert_off_when_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prd == '0) |=> (cnt == '0 && !pulse));

endmodule

// File: rtl/socgen.sv
// Module socgen
// Top of the start-of-conversion pulser. It builds four channels, or only A
// and B when FOUR_CH is 0. Every channel has its own event pick and its own
// prescaler. Only channels A and B have a mix path. Assumes event strobes are
// synchronous and last one cycle each.
module socgen
    import socgen_pkg::*;
#(
    parameter bit FOUR_CH = 1'b1,
    parameter int PW      = 3,
    localparam int NCH    = FOUR_CH ? 4 : 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EVT-1:0]   tb_evt,
    input  logic [NCH*SEL_W-1:0] ch_sel,
    input  logic [NCH*PW-1:0]    ch_prd,
    input  logic [NCH-1:0]       ch_en,
    input  logic [NCH-1:0]       ch_clr,
    input  logic [NUM_EVT-1:0]   mix_mask_a,
    input  logic [NUM_EVT-1:0]   mix_mask_b,
    output logic [NCH-1:0]       soc_pulse,
    output logic [NCH-1:0]       soc_flag,
    output logic [NCH*PW-1:0]    soc_cnt
);

    logic [NCH-1:0] hit;

    // One event pick and one prescaler per channel
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            localparam bit C_MIX = (c < 2);
            logic [NUM_EVT-1:0] mask;

            // Channel A uses mask A, channel B mask B, others none
            if (c == 0) begin : g_ma
                assign mask = mix_mask_a;
            end else if (c == 1) begin : g_mb
                assign mask = mix_mask_b;
            end else begin : g_mn
                assign mask = '0;
            end

            soc_evt_pick #(.HAS_MIX(C_MIX)) u_pick (
                .evt      (tb_evt),
                .sel      (ch_sel[c*SEL_W +: SEL_W]),
                .mix_mask (mask),
                .hit      (hit[c])
            );

            soc_chan #(.PW(PW)) u_chan (
                .clk   (clk),
                .rst_n (rst_n),
                .hit   (hit[c]),
                .prd   (ch_prd[c*PW +: PW]),
                .en    (ch_en[c]),
                .clr   (ch_clr[c]),
                .pulse (soc_pulse[c]),
                .flag  (soc_flag[c]),
                .cnt   (soc_cnt[c*PW +: PW])
            );
        end
    endgenerate

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (soc_pulse == '0 && soc_flag == '0 && soc_cnt == '0));

endmodule

// File: tb/socgen_bench.sv
`timescale 1ns/1ps
module socgen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] evt = '0;
    logic [15:0] sel = '0;
    logic [11:0] prd = '0;
    logic [3:0]  en  = '0;
    logic [3:0]  clr = '0;
    logic [11:0] ma  = '0;
    logic [11:0] mb  = '0;
    logic [3:0]  pulse, flag;
    logic [11:0] cnt;
    logic [1:0]  n_pulse, n_flag;
    logic [5:0]  n_cnt;

    logic [2:0]  m_cnt [4];
    logic        m_flag[4];
    logic        m_pulse[4];

    int    n_chk = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    done = 0;

    always #5 clk = ~clk;

    socgen u_socgen (
        .clk(clk), .rst_n(rst_n), .tb_evt(evt), .ch_sel(sel), .ch_prd(prd),
        .ch_en(en), .ch_clr(clr), .mix_mask_a(ma), .mix_mask_b(mb),
        .soc_pulse(pulse), .soc_flag(flag), .soc_cnt(cnt)
    );

    socgen #(.FOUR_CH(1'b0)) u_socgen_two (
        .clk(clk), .rst_n(rst_n), .tb_evt(evt), .ch_sel(sel[7:0]), .ch_prd(prd[5:0]),
        .ch_en(en[1:0]), .ch_clr(clr[1:0]), .mix_mask_a(ma), .mix_mask_b(mb),
        .soc_pulse(n_pulse), .soc_flag(n_flag), .soc_cnt(n_cnt)
    );

    // Spec of the select codes (R8, R9)
    function automatic logic pick_hit(int ch, logic [3:0] s, logic [11:0] e);
        case (s)
            4'd1:  return e[0];
            4'd2:  return e[1];
            4'd3:  return e[0] | e[1];
            4'd14: return (ch == 0) ? |(e & ma) : (ch == 1) ? |(e & mb) : 1'b0;
            4'd0, 4'd15: return 1'b0;
            default: return e[s - 4'd2];
        endcase
    endfunction

    // Expected state after one clock edge, from the requirements
    task automatic model_step();
        for (int c = 0; c < 4; c++) begin
            logic [2:0] p = prd[c*3 +: 3];
            logic       h = pick_hit(c, sel[c*4 +: 4], evt);
            logic [2:0] n = m_cnt[c] + ((h && m_cnt[c] < p) ? 3'd1 : 3'd0);
            logic       f = (p != 0) && (n >= p) && en[c];
            m_pulse[c] = f;
            m_cnt[c]   = (p == 0 || f) ? 3'd0 : n;
            if (f) m_flag[c] = 1'b1;
            else if (clr[c]) m_flag[c] = 1'b0;
        end
    endtask

    task automatic chk(string t, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int c = 0; c < 4; c++) begin
            chk(tag, $sformatf("ch%0d pulse", c), int'(pulse[c]), int'(m_pulse[c]));
            chk(tag, $sformatf("ch%0d flag", c), int'(flag[c]), int'(m_flag[c]));
            chk(tag, $sformatf("ch%0d cnt", c), int'(cnt[c*3 +: 3]), int'(m_cnt[c]));
        end
        // R10: narrow build tracks channels A and B
        chk("R10", "two-ch pulse", int'(n_pulse), int'(pulse[1:0]));
        chk("R10", "two-ch flag", int'(n_flag), int'(flag[1:0]));
        chk("R10", "two-ch cnt", int'(n_cnt), int'(cnt[5:0]));
    endtask

    // One clock: predict, advance, sample at the falling edge, drop strobes
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        evt = '0;
        clr = '0;
    endtask

    task automatic set_ch(int c, logic [3:0] s, logic [2:0] p, logic e);
        sel[c*4 +: 4] = s;
        prd[c*3 +: 3] = p;
        en[c]         = e;
    endtask

    task automatic quiet_all();
        sel = '0; prd = '0; en = '0; evt = '0; clr = '0;
        cycle();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            m_cnt[c] = '0; m_flag[c] = 1'b0; m_pulse[c] = 1'b0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state, then first sample after release
        tag = "R1";
        compare_all();
        rst_n = 1'b1;
        cycle();

        // R2 / R3: zero strobe every cycle, period 3 on channel A
        tag = "R2";
        set_ch(0, 4'd1, 3'd3, 1'b1);
        for (int i = 0; i < 9; i++) begin
            tag = (i % 3 == 0) ? "R3" : "R2";
            evt = 12'h001;
            cycle();
        end

        // R6: channel B disabled, count stops at period 2, then enable fires
        tag = "R6";
        set_ch(1, 4'd2, 3'd2, 1'b0);
        for (int i = 0; i < 4; i++) begin
            evt = 12'h002;
            cycle();
        end
        en[1] = 1'b1;
        cycle();
        cycle();

        // R7: period 0 on channel C with trip strobes
        tag = "R7";
        set_ch(2, 4'd12, 3'd0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            evt = 12'h400;
            cycle();
        end

        // R5: clear alone, then clear colliding with a pulse
        tag = "R5";
        clr[0] = 1'b1;
        cycle();
        set_ch(0, 4'd1, 3'd1, 1'b1);
        evt = 12'h001;
        clr[0] = 1'b1;
        cycle();

        // R4: period 1 with back-to-back strobes, flag already set
        tag = "R4";
        for (int i = 0; i < 4; i++) begin
            evt = 12'h001;
            cycle();
        end

        // R9: mix on A matches mask, unmasked strobe ignored; mix on C inert
        quiet_all();
        tag = "R9";
        ma = 12'h020;
        set_ch(0, 4'd14, 3'd1, 1'b1);
        set_ch(2, 4'd14, 3'd1, 1'b1);
        evt = 12'h020; cycle();
        evt = 12'h010; cycle();
        evt = 12'hFFF; cycle();
        mb = 12'h800;
        set_ch(1, 4'd14, 3'd1, 1'b1);
        evt = 12'h800; cycle();
        evt = 12'h7FF; cycle();

        // R11: period lowered under the live count on channel D
        quiet_all();
        tag = "R11";
        set_ch(3, 4'd1, 3'd6, 1'b1);
        for (int i = 0; i < 4; i++) begin
            evt = 12'h001;
            cycle();
        end
        prd[9 +: 3] = 3'd2;
        cycle();
        cycle();

        // R8: random selects, periods, enables, clears and strobes
        tag = "R8";
        for (int blk = 0; blk < 60; blk++) begin
            for (int c = 0; c < 4; c++)
                set_ch(c, 4'($urandom_range(0, 15)), 3'($urandom_range(0, 7)),
                       ($urandom_range(0, 3) != 0));
            ma = 12'($urandom);
            mb = 12'($urandom);
            for (int i = 0; i < 40; i++) begin
                evt = 12'($urandom) & 12'($urandom);
                clr = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
                if ($urandom_range(0, 15) == 0) en = 4'($urandom);
                cycle();
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule